// File: doc/BRIEF.md
# Gray-Code Countdown Counter Bank

This block holds a bank of up-only counters whose state is kept in Gray code. On every enabled tick exactly one stored bit flips, which limits switching activity and the noise it causes. Each counter has its own tick enable. A counter stops when its state reaches zero, and it then raises its completion flag.

Software never sees either the Gray encoding or the upward direction. It writes a positive number of ticks to wait through a small address/data register bus, and it reads back the positive number of ticks still remaining. One translator serves every counter, and it is used only when the bus is accessed. On a write it negates the value modulo 2^W and converts the result to Gray before storing it. On a read it converts the selected Gray state back to binary and negates it. The raw Gray state of every counter is also brought out so that downstream logic can watch it.

Top module: `grayCountBank`

## Requirements
- R1: After reset every counter state is zero, every completion flag is high, and the read data is zero.
- R2: Writing a count N (0 to 2^W-1) to a counter and then reading that counter with no tick in between returns N.
- R3: Each clock cycle with a counter's tick enable high lowers that counter's read-back count by one. A counter whose enable is low keeps its value.
- R4: Each enabled tick on a nonzero counter changes exactly one bit of its exposed Gray state.
- R5: When the count reaches zero the completion flag for that counter goes high. The state then stays zero while ticks continue, and the read-back count stays 0.
- R6: A write and a tick to the same counter in the same cycle load the written value. The tick is lost.
- R7: An address at or above the number of counters does not affect any counter when written, and reads as zero.
- R8: The read data register updates on the clock edge where the read enable is sampled and holds otherwise. A read and a write to the same counter in one cycle return the count as it stood before the write.
- R9: After a write of N, the exposed state of counter i in bits [i*W +: W] equals b ^ (b >> 1), where b = (2^W - N) mod 2^W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the bus |
| rdEn | input | 1 | Read strobe for the bus |
| addr | input | ADDR_W | Counter index for the access |
| wrData | input | CNT_W | Positive count to load |
| rdData | output | CNT_W | Remaining positive count, registered |
| tickEn | input | NUM_CNT | Per-counter tick enable |
| cntGray | output | NUM_CNT*CNT_W | Raw Gray state, counter i in bits [i*CNT_W +: CNT_W] |
| done | output | NUM_CNT | Per-counter completion flag |

## Verification
A table of load values, tick counts and expected remaining counts covers several things. It includes partial countdowns, countdowns that run past zero, loads of zero and of full scale, and loads with no ticks at all. Between them these separate a correct negation from an off-by-one or a missing wrap. Separate runs from full scale down to zero at widths 3, 6 and 8 compare each Gray state with the one before it, so a plain binary increment or a wrong conversion shows up as a multi-bit step. Directed cases then set a tick against a write in the same cycle, a read against a write in the same cycle, and accesses to unused addresses. These tell apart the priority and ordering choices.

// File: rtl/grayBankPkg.sv
package grayBankPkg;
  // Strobes passed from the bus decoder to the datapath.
  typedef struct packed {
    logic rdStrobe;  // a read is being sampled this cycle
    logic inRange;   // the address selects an existing counter
  } bankStrobes_t;
endpackage

// File: rtl/grayBankCtrl.sv
module grayBankCtrl
  import grayBankPkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ADDR_W  = 3
) (
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [ADDR_W-1:0]  addr,
  output bankStrobes_t       strobes,
  output logic [NUM_CNT-1:0] loadHot
);
  localparam int CMP_W = ADDR_W + 1;

  logic addrOk;
  assign addrOk = {1'b0, addr} < CMP_W'(NUM_CNT);

  assign strobes.rdStrobe = rdEn;
  assign strobes.inRange  = addrOk;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
    assign loadHot[i] = wrEn && addrOk && (addr == ADDR_W'(i));
  end

  // R7: an unused address never produces a load strobe
  always_comb begin
    if (wrEn && !addrOk) assert (loadHot == '0) else $error("p_oob_no_load_r7");
  end
endmodule

// File: rtl/grayBankXlate.sv
module grayBankXlate #(
  parameter int W = 8
) (
  input  logic [W-1:0] loadCount,  // positive count from software
  output logic [W-1:0] loadGray,   // negated, Gray-coded state to store
  input  logic [W-1:0] readGray,   // selected stored state
  output logic [W-1:0] readCount   // positive remaining count
);
  logic [W-1:0] negLoad;
  logic [W-1:0] readBin;

  assign negLoad  = '0 - loadCount;
  assign loadGray = negLoad ^ (negLoad >> 1);

  // prefix XOR from the top bit down
  always_comb begin
    readBin[W-1] = readGray[W-1];
    for (int k = W - 2; k >= 0; k--) begin
      readBin[k] = readBin[k+1] ^ readGray[k];
    end
  end

  assign readCount = '0 - readBin;
endmodule

// File: rtl/grayBankDatapath.sv
module grayBankDatapath
  import grayBankPkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int W       = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobes_t         strobes,
  input  logic [NUM_CNT-1:0]   loadHot,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [NUM_CNT-1:0]   tickEn,
  input  logic [W-1:0]         loadGray,
  input  logic [W-1:0]         readCount,
  output logic [W-1:0]         selGray,
  output logic [W-1:0]         rdData,
  output logic [NUM_CNT*W-1:0] cntGray,
  output logic [NUM_CNT-1:0]   done
);
  logic [W-1:0] cntArr [NUM_CNT];

  function automatic logic [W-1:0] nextGray(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int k = W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    b = b + W'(1);
    return b ^ (b >> 1);
  endfunction

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntArr[i] <= '0;
      end else if (loadHot[i]) begin
        cntArr[i] <= loadGray;
      end else if (tickEn[i] && (cntArr[i] != '0)) begin
        cntArr[i] <= nextGray(cntArr[i]);
      end
    end

    assign cntGray[i*W +: W] = cntArr[i];
    assign done[i]           = (cntArr[i] == '0);

    // R3: no tick and no load leaves the state alone
    p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!loadHot[i] && !tickEn[i]) |=> $stable(cntArr[i]));

    // R4: a tick on a running counter flips exactly one bit
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rstN)
      (!loadHot[i] && tickEn[i] && (cntArr[i] != '0))
      |=> ($countones(cntArr[i] ^ $past(cntArr[i])) == 1));

    // R5: a finished counter stays finished until reloaded
    p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
      (!loadHot[i] && (cntArr[i] == '0)) |=> (cntArr[i] == '0));

    // R6: a load wins over a tick in the same cycle
    p_load_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
      loadHot[i] |=> (cntArr[i] == $past(loadGray)));
  end

  // read mux feeding the shared translator
  always_comb begin
    selGray = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ADDR_W'(i)) selGray = cntArr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (strobes.rdStrobe) begin
      rdData <= strobes.inRange ? readCount : '0;
    end
  end

  // R7: reads of an unused address return zero
  p_oob_read_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.rdStrobe && !strobes.inRange) |=> (rdData == '0));

  // R8: read data holds when no read is sampled
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdStrobe |=> $stable(rdData));
endmodule

// File: rtl/grayCountBank.sv
module grayCountBank
  import grayBankPkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 8,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic                     rdEn,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [CNT_W-1:0]         wrData,
  output logic [CNT_W-1:0]         rdData,
  input  logic [NUM_CNT-1:0]       tickEn,
  output logic [NUM_CNT*CNT_W-1:0] cntGray,
  output logic [NUM_CNT-1:0]       done
);
  bankStrobes_t       strobes;
  logic [NUM_CNT-1:0] loadHot;
  logic [CNT_W-1:0]   loadGray;
  logic [CNT_W-1:0]   selGray;
  logic [CNT_W-1:0]   readCount;

  grayBankCtrl #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .addr    (addr),
    .strobes (strobes),
    .loadHot (loadHot)
  );

  grayBankXlate #(.W(CNT_W)) u_xlate (
    .loadCount (wrData),
    .loadGray  (loadGray),
    .readGray  (selGray),
    .readCount (readCount)
  );

  grayBankDatapath #(.NUM_CNT(NUM_CNT), .W(CNT_W), .ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadHot   (loadHot),
    .addr      (addr),
    .tickEn    (tickEn),
    .loadGray  (loadGray),
    .readCount (readCount),
    .selGray   (selGray),
    .rdData    (rdData),
    .cntGray   (cntGray),
    .done      (done)
  );
endmodule

// File: tb/grayCountBank_test.sv
module grayCountBank_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic       rdEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] tickEn = '0;

  logic [7:0]  rd8;
  logic [31:0] gray8;
  logic [3:0]  done8;
  logic [5:0]  rd6;
  logic [11:0] gray6;
  logic [1:0]  done6;
  logic [2:0]  rd3;
  logic [5:0]  gray3;
  logic [1:0]  done3;

  int passCnt = 0;
  int totalCnt = 0;

  always #2 clk = ~clk;  // 250 MHz

  grayCountBank #(.NUM_CNT(4), .CNT_W(8), .ADDR_W(3)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rd8), .tickEn(tickEn), .cntGray(gray8), .done(done8));

  grayCountBank #(.NUM_CNT(2), .CNT_W(6), .ADDR_W(3)) uut6 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData[5:0]), .rdData(rd6), .tickEn(tickEn[1:0]), .cntGray(gray6), .done(done6));

  grayCountBank #(.NUM_CNT(2), .CNT_W(3), .ADDR_W(3)) uut3 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData[2:0]), .rdData(rd3), .tickEn(tickEn[1:0]), .cntGray(gray3), .done(done3));

  typedef struct packed {
    logic [2:0] a;
    logic [7:0] v;
    logic [8:0] t;
    logic [7:0] e;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 8'd200, 9'd50,  8'd150},
    '{3'd1, 8'd1,   9'd1,   8'd0},
    '{3'd2, 8'd0,   9'd3,   8'd0},
    '{3'd3, 8'd255, 9'd10,  8'd245},
    '{3'd0, 8'd5,   9'd9,   8'd0},
    '{3'd1, 8'd128, 9'd128, 8'd0},
    '{3'd2, 8'd100, 9'd0,   8'd100},
    '{3'd3, 8'd17,  9'd16,  8'd1}
  };

  task automatic check(input string tag, input int act, input int exp);
    totalCnt++;
    if (act == exp) passCnt++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  function automatic logic [7:0] grayOf8(input logic [7:0] n);
    logic [7:0] b;
    b = 8'd0 - n;
    return b ^ (b >> 1);
  endfunction

  task automatic doWrite(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [7:0] r);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    r = rd8;
  endtask

  task automatic doTicks(input logic [3:0] mask, input int n);
    if (n > 0) begin
      @(negedge clk);
      tickEn = mask;
      repeat (n) @(negedge clk);
      tickEn = '0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", passCnt, totalCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    totalCnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0]  r;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 done", done8, 4'hF);
    check("R1 gray", gray8, 0);
    check("R1 rdData", rd8, 0);
    doRead(3'd2, r);
    check("R1 read", r, 0);

    // table walk: R2, R3, R5, R9
    for (int i = 0; i < NVEC; i++) begin
      doWrite(VECS[i].a, VECS[i].v);
      check("R9 gray after write", gray8[VECS[i].a*8 +: 8], grayOf8(VECS[i].v));
      doTicks(4'b0001 << VECS[i].a, int'(VECS[i].t));
      doRead(VECS[i].a, r);
      check("R3 remaining", r, VECS[i].e);
      check("R5 done flag", done8[VECS[i].a], (VECS[i].e == 0) ? 1 : 0);
    end

    // R2: round trip with no ticks, boundary values
    doWrite(3'd1, 8'd255);
    doRead(3'd1, r);
    check("R2 full scale", r, 255);
    doWrite(3'd1, 8'd0);
    doRead(3'd1, r);
    check("R2 zero", r, 0);
    check("R5 zero load done", done8[1], 1);

    // R3: independence of per-counter enables
    doWrite(3'd2, 8'd100);
    doWrite(3'd3, 8'd50);
    doTicks(4'b0100, 10);
    doRead(3'd2, r);
    check("R3 ticked counter", r, 90);
    doRead(3'd3, r);
    check("R3 idle counter", r, 50);

    // R6: tick and write to the same counter in one cycle
    doTicks(4'b1000, 0);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd3; wrData = 8'd40; tickEn = 4'b1100;
    @(negedge clk);
    wrEn = 1'b0; tickEn = '0;
    doRead(3'd3, r);
    check("R6 load wins", r, 40);
    doRead(3'd2, r);
    check("R6 other counter ticked", r, 89);

    // R8: read and write same counter, same cycle -> old value
    @(negedge clk);
    wrEn = 1'b1; rdEn = 1'b1; addr = 3'd2; wrData = 8'd7;
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    check("R8 read before write", rd8, 89);
    repeat (2) @(negedge clk);
    check("R8 rdData holds", rd8, 89);
    doRead(3'd2, r);
    check("R8 new value later", r, 7);

    // R7: unused addresses
    snap = gray8;
    doWrite(3'd5, 8'd33);
    check("R7 write ignored", gray8, snap);
    doRead(3'd6, r);
    check("R7 read zero", r, 0);

    // R4 and R5: full-range countdowns at widths 8, 6 and 3
    doWrite(3'd0, 8'hFF);
    begin
      logic [7:0] p8;
      logic [5:0] p6;
      logic [2:0] p3;
      @(negedge clk);
      tickEn = 4'b0001;
      p8 = gray8[7:0]; p6 = gray6[5:0]; p3 = gray3[2:0];
      for (int c = 0; c < 260; c++) begin
        @(negedge clk);
        check("R4 w8 step", $countones(gray8[7:0] ^ p8), (p8 != 0) ? 1 : 0);
        check("R4 w6 step", $countones(gray6[5:0] ^ p6), (p6 != 0) ? 1 : 0);
        check("R4 w3 step", $countones(gray3[2:0] ^ p3), (p3 != 0) ? 1 : 0);
        p8 = gray8[7:0]; p6 = gray6[5:0]; p3 = gray3[2:0];
      end
      tickEn = '0;
    end
    check("R5 w8 done", done8[0], 1);
    check("R5 w6 done", done6[0], 1);
    check("R5 w3 done", done3[0], 1);
    doRead(3'd0, r);
    check("R5 w8 read zero", r, 0);
    check("R5 w6 read zero", rd6, 0);
    check("R5 w3 read zero", rd3, 0);

    summary();
    $finish;
  end
endmodule